// File: doc/BRIEF.md
# Serial Attenuator Command Transmitter

This block sits on the host side of a three-wire volume-attenuator link. A client hands it an 8-bit attenuation code over a valid/ready handshake. The block then drives a 16-bit frame out on a serial data line, a serial clock and an active-low load strobe. The frame is an address byte that is always zero, followed by the attenuation byte.

All link timing comes from the system clock. One parameter sets how many cycles the load strobe is held low before the first serial clock rise. A second parameter sets the length of each high and low serial clock phase. Between frames the serial clock idles low and the load strobe idles high. The block keeps the serial clock low whenever the load strobe moves, so the strobe's falling edge never trails a clock falling edge. Raising the strobe after the sixteenth bit commits the setting in the receiver. One cycle later, a single-cycle completion pulse is issued.

Top module: `atten_cmd_tx`

## Requirements
- R1: After reset `ser_load` is 1, `ser_clk` is 0, `ser_data` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. While a frame is in progress `req_ready` is 0, and a `req_valid` held then starts no frame and is never transmitted.
- R3: Each frame carries exactly 16 bits, sampled on the rising edges of `ser_clk`. Bits 1 to 8 are all 0 (the address byte). Bits 9 to 16 are `req_atten[7]` down to `req_atten[0]`, most significant bit first.
- R4: `ser_load` falls exactly `SETUP_CYC` system-clock cycles before the first rising edge of `ser_clk` in the frame. The default of 38 cycles at 250 MHz is 152 ns.
- R5: Every high phase of `ser_clk` and every low phase between two bits lasts exactly `HALF_CYC` system-clock cycles.
- R6: `ser_clk` is 0 in every cycle where `ser_load` is 1 and in every cycle where `ser_load` changes.
- R7: `ser_data` changes only in cycles where `ser_clk` is 0, so it is stable across each rising edge and throughout each high phase.
- R8: `ser_load` stays 0 from its fall until all 16 bits are sent. It rises `HALF_CYC` cycles after the 16th falling edge of `ser_clk`.
- R9: `done` is 1 for exactly one cycle: the cycle after `ser_load` rises. `req_ready` is 1 again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers an attenuation code |
| req_ready | output | 1 | Block is idle and will take a request |
| req_atten | input | ATTEN_W | Attenuation code to send |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_load | output | 1 | Load strobe, low during a frame |
| done | output | 1 | One-cycle pulse after the frame is committed |

## Verification
A wrong phase counter shows up quickly. It appears at the first serial clock edge as a setup or half-period length that is off, and the edge-to-edge counts expose it within one phase. A wrong bit index or shifter state shows only when the load strobe rises. At that point the captured frame has the wrong length, a nonzero address byte or a corrupted data byte, so the error becomes visible about 170 cycles after acceptance. A sequencer stuck outside idle shows as `req_ready` never returning and a missing `done`. A sequencer that leaves idle early shows as a request accepted while busy, which produces an unexpected frame with no matching entry in the scoreboard.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_DONE  = 3'd4
  } atc_state_e;
endpackage

// File: rtl/atc_timer.sv
// Down-counter for phase lengths. Loading VAL gives VAL+1 cycles until expiry.
module atc_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= start_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/atc_shifter.sv
// Frame register: loads in parallel and shifts left. Its MSB drives the line.
module atc_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= din;
    end else if (shift) begin
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end

  assign msb = sreg[W-1];
endmodule

// File: rtl/atc_fsm.sv
// Frame sequencer: strobe setup, clock phases, bit count, commit and done.
module atc_fsm
  import atc_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int SETUP_CYC = 38,
  parameter int HALF_CYC  = 4,
  parameter int TW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          tmr_zero,
  output logic          req_ready,
  output logic          accept,
  output logic          tmr_start,
  output logic [TW-1:0] tmr_val,
  output logic          sh_shift,
  output logic          ser_clk,
  output logic          ser_load,
  output logic          done
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);

  atc_state_e    state;
  logic [BW-1:0] bit_idx;
  logic          last_bit;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_bit  = (bit_idx == LAST_BIT);

  always_comb begin
    tmr_start = 1'b0;
    tmr_val   = '0;
    sh_shift  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          tmr_start = 1'b1;
          tmr_val   = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          tmr_start = 1'b1;
          tmr_val   = HALF_LD;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          tmr_start = 1'b1;
          tmr_val   = HALF_LD;
          sh_shift  = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_zero && !last_bit) begin
          tmr_start = 1'b1;
          tmr_val   = HALF_LD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      ser_clk  <= 1'b0;
      ser_load <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SETUP;
            ser_load <= 1'b0;
            bit_idx  <= '0;
          end
        end
        ST_SETUP: begin
          if (tmr_zero) begin
            state   <= ST_HIGH;
            ser_clk <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr_zero) begin
            state   <= ST_LOW;
            ser_clk <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tmr_zero) begin
            if (last_bit) begin
              state    <= ST_DONE;
              ser_load <= 1'b1;
            end else begin
              state   <= ST_HIGH;
              ser_clk <= 1'b1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atten_cmd_tx.sv
module atten_cmd_tx #(
  parameter int ATTEN_W   = 8,
  parameter int ADDR_W    = 8,
  parameter int SETUP_CYC = 38,
  parameter int HALF_CYC  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ATTEN_W-1:0] req_atten,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               ser_load,
  output logic               done
);
  localparam int FRAME_W = ADDR_W + ATTEN_W;
  localparam int MAXC    = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int TW      = $clog2(MAXC + 1);

  logic          accept;
  logic          tmr_start;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          sh_shift;
  logic [FRAME_W-1:0] frame;

  assign frame = {{ADDR_W{1'b0}}, req_atten};

  atc_fsm #(
    .FRAME_W  (FRAME_W),
    .SETUP_CYC(SETUP_CYC),
    .HALF_CYC (HALF_CYC),
    .TW       (TW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .tmr_zero (tmr_zero),
    .req_ready(req_ready),
    .accept   (accept),
    .tmr_start(tmr_start),
    .tmr_val  (tmr_val),
    .sh_shift (sh_shift),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .done     (done)
  );

  atc_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (tmr_start),
    .start_val(tmr_val),
    .expired  (tmr_zero)
  );

  atc_shifter #(.W(FRAME_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .din  (frame),
    .shift(sh_shift),
    .msb  (ser_data)
  );
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int SETUP_CYC = 38,
  parameter int HALF_CYC  = 4
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_load,
  input logic done
);
  localparam int CW = $clog2(SETUP_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] low_cnt;
  logic          first_pend;

  always_ff @(posedge clk) begin
    if (rst || ser_load) begin
      low_cnt    <= '0;
      first_pend <= 1'b1;
    end else begin
      if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
      if (ser_clk) first_pend <= 1'b0;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !ser_load && !req_ready);                 // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !ser_load |-> !req_ready);                                           // R2
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) && first_pend |-> low_cnt >= CW'(SETUP_CYC));         // R4
  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    ser_load |-> !ser_clk);                                              // R6
  AST_CLK_LOW_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_load) || $fell(ser_load) |-> !ser_clk);                    // R6
  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> !ser_clk);                                    // R7
  AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    done |-> ser_load && $past(ser_load) && !$past(ser_load, 2));        // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                     // R9
endmodule

bind atten_cmd_tx atc_checker #(
  .SETUP_CYC(SETUP_CYC),
  .HALF_CYC (HALF_CYC)
) u_atc_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .ser_data (ser_data),
  .ser_clk  (ser_clk),
  .ser_load (ser_load),
  .done     (done)
);

// File: tb/atten_cmd_tx_tb.sv
`timescale 1ns/1ps
module atten_cmd_tx_tb;
  localparam int SETUP_CYC = 38;
  localparam int HALF_CYC  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_atten = 8'h00;
  logic       req_ready, ser_data, ser_clk, ser_load, done;

  always #2 clk = ~clk;

  atten_cmd_tx #(.SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_atten(req_atten), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load(ser_load), .done(done)
  );

  logic [7:0] exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int n_push = 0;
  int n_frames = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: offer a code, wait for the handshake, then record the expectation.
  task automatic send(input logic [7:0] code);
    @(negedge clk);
    req_valid = 1'b1;
    req_atten = code;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(code);
    n_push++;
    req_valid = 1'b0;
  endtask

  // Monitor: reconstructs frames and times edges on the serial pins.
  bit        p_load = 1, p_clk = 0, p_data = 0, done_due = 0;
  int        s_cnt = 0, hi_cnt = 0, lo_cnt = 0, bits = 0;
  logic [15:0] frame = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_load != p_load) chk(ser_clk == 1'b0, "R6 clk low at strobe edge", ser_clk, 0);
      if (ser_load && ser_clk) chk(0, "R6 clk toggled while idle", 1, 0);
      if (!ser_load) begin
        if (req_ready) chk(0, "R2 ready while busy", 1, 0);
        if (p_load) begin s_cnt = 0; bits = 0; frame = '0; end
        if (ser_clk && !p_clk) begin
          if (bits == 0) chk(s_cnt == SETUP_CYC, "R4 setup cycles", s_cnt, SETUP_CYC);
          else           chk(lo_cnt == HALF_CYC, "R5 low phase", lo_cnt, HALF_CYC);
          frame = {frame[14:0], ser_data};
          bits++;
          hi_cnt = 1;
        end else if (ser_clk) begin
          hi_cnt++;
          if (ser_data != p_data) chk(0, "R7 data moved while clk high", ser_data, p_data);
        end else if (p_clk) begin
          chk(hi_cnt == HALF_CYC, "R5 high phase", hi_cnt, HALF_CYC);
          lo_cnt = 1;
        end else begin
          if (bits == 0) s_cnt++;
          else lo_cnt++;
        end
      end
      if (done_due) begin
        chk(done == 1'b1, "R9 done after commit", done, 1);
        chk(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
        done_due = 0;
      end else if (done) begin
        chk(0, "R9 stray done", 1, 0);
      end
      if (ser_load && !p_load) begin
        n_frames++;
        chk(bits == 16, "R8 bit count", bits, 16);
        chk(lo_cnt == HALF_CYC, "R8 strobe rise after last fall", lo_cnt, HALF_CYC);
        chk(frame[15:8] == 8'h00, "R3 address byte", frame[15:8], 0);
        if (exp_q.size() == 0) begin
          chk(0, "R2 frame without accepted request", frame[7:0], -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(frame[7:0] == e, "R3 data byte", frame[7:0], e);
        end
        done_due = 1;
      end
      p_load = ser_load; p_clk = ser_clk; p_data = ser_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ser_load == 1'b1, "R1 load idle", ser_load, 1);
    chk(ser_clk == 1'b0, "R1 clk idle", ser_clk, 0);
    chk(ser_data == 1'b0, "R1 data idle", ser_data, 0);
    chk(done == 1'b0, "R1 done idle", done, 0);
    chk(req_ready == 1'b1, "R1 ready idle", req_ready, 1);

    send(8'h00);
    send(8'hFF);
    send(8'hA5);
    send(8'h3E);
    // R2: request held while busy must be ignored
    send(8'h12);
    repeat (5) @(negedge clk);
    req_valid = 1'b1;
    req_atten = 8'hC3;
    repeat (30) @(negedge clk);
    chk(req_ready == 1'b0, "R2 busy holds ready low", req_ready, 0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ser_load == 1'b1, "R2 no frame from busy request", ser_load, 1);
    // back-to-back requests
    send(8'h40);
    send(8'h01);
    send(8'h80);
    while (exp_q.size() != 0 || !ser_load) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(n_frames == n_push, "R2 frame count", n_frames, n_push);
    chk(ser_data == 1'b0, "R1 data idle after frames", ser_data, 0);
    wrap_up();
  end
endmodule